// File: doc/BRIEF.md
# ADC Result Bank with Status Flags

This block sits between a multi-channel analog-to-digital converter core and the system bus. Each time the core reports a finished conversion it supplies a channel number and a raw sample. The block stores the sample, right-aligned, in two places: that channel's own result register and a shared most-recent-result register. It then records the event in a set of flags. Each channel has a "new data" flag and an "overwritten unread data" flag. A global data-ready flag and a global overwrite flag cover all channels.

Software or a DMA engine collects results through a simple read port. Reads have side effects:
- Fetching a result clears the flags that announced it.
- Fetching the status word clears the overwrite flags.

A maskable interrupt reflects the per-channel new-data flags and the global data-ready flag. A one-cycle DMA request fires whenever data-ready goes from low to high.

Top module: `adc_result_bank`

## Requirements
- R1: With `res8`=1 the stored value is `conv_data[7:0]` with bits [9:8] zero; with `res8`=0 the stored value is all ten bits of `conv_data`.
- R2: A completion (`conv_done`=1) writes the value into the register of `conv_ch` (read address = channel number, 0..7) and into the most-recent register (address 8). The most-recent register reads as the value in bits [9:0] and the channel in bits [12:10]. The other channel registers do not change.
- R3: A completion sets the new-data flag of `conv_ch` and the data-ready flag, seen at the first clock edge after it. The status word (address 9) holds new-data flags in bits [7:0], overwrite flags in [15:8], data-ready in bit 16 and global overwrite in bit 17.
- R4: A read strobe (`rd_en`=1) at a channel address clears that channel's new-data flag and data-ready. It leaves the other flags unchanged.
- R5: A read strobe at address 8 clears data-ready and the new-data flag of the channel converted most recently, and only that new-data flag.
- R6: A completion for a channel whose new-data flag is already set sets that channel's overwrite flag. A completion for a channel whose new-data flag is clear leaves that overwrite flag unchanged.
- R7: A completion while data-ready is set sets the global overwrite flag.
- R8: A read strobe at address 9 clears all per-channel overwrite flags and the global overwrite flag. It leaves the new-data flags and data-ready unchanged.
- R9: `dma_req` is high for exactly the one cycle in which data-ready first reads high after being low, and only if `dma_en` was high at that completion.
- R10: `irq` is the OR of the set flags whose mask bit is set. `mask_wdata` bits [7:0] enable the per-channel new-data flags and bit 8 enables data-ready. The mask is loaded when `mask_we`=1.
- R11: When a completion and a clearing read happen in the same cycle, the completion's sets win. The overwrite checks use the flag values from before the read.
- R12: Synchronous active-low reset clears all registers, all flags, the mask and `dma_req`. Addresses 10 to 15 read as zero and a read strobe there changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res8 | input | 1 | 1 selects 8-bit results, 0 selects 10-bit |
| conv_done | input | 1 | Conversion-complete pulse from the converter core |
| conv_ch | input | 3 | Channel of the completed conversion |
| conv_data | input | 10 | Raw sample, right-aligned |
| rd_en | input | 1 | Read strobe; triggers the side-effect clears |
| rd_addr | input | 4 | Read address: 0..7 channel, 8 most recent, 9 status |
| rd_data | output | 18 | Combinational read data for `rd_addr` |
| mask_we | input | 1 | Load the interrupt mask |
| mask_wdata | input | 9 | New interrupt mask |
| dma_en | input | 1 | Allows DMA requests |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA transfer request |

## Verification
The hardest situations to reach are the collisions: a clearing read that lands in the same cycle as a new completion for the same channel, and a status read that lands in the same cycle as a fresh overwrite. In both, the order of set and clear decides the result. The bench first builds a known flag state with unread conversions. It then drives `conv_done` and `rd_en` in one cycle and inspects the status word without a strobe, because `rd_data` can be read with `rd_en` low and so has no side effect. A sweep over all eight channels in both resolutions covers storage, flags and the DMA edge. The bench model predicts every value from the rules above.

// File: rtl/adc_result_pkg.sv
// Package adc_result_pkg
// Shared types for the ADC result bank: the kind of register a read
// address selects.
package adc_result_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CHAN = 2'd1,
        RK_LAST = 2'd2,
        RK_STAT = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/adc_read_decode.sv
// Module adc_read_decode
// Splits a read address into the kind of register it selects. Produces
// the side-effect clear vectors that a read strobe implies.
// Assumes: addresses 0..NUM_CH-1 are channels, NUM_CH is the most
// recent result, NUM_CH+1 is status, and anything else is unmapped.
module adc_read_decode
    import adc_result_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CH_W-1:0]   last_ch,
    output rd_kind_e          kind,
    output logic [CH_W-1:0]   sel_ch,
    output logic [NUM_CH-1:0] eoc_clr,
    output logic              drdy_clr,
    output logic              ovr_clr
);

    localparam int LAST_ADDR = NUM_CH;
    localparam int STAT_ADDR = NUM_CH + 1;

    // Classify the address (independent of the strobe).
    always_comb begin
        sel_ch = rd_addr[CH_W-1:0];
        if (int'(rd_addr) < NUM_CH)           kind = RK_CHAN;
        else if (int'(rd_addr) == LAST_ADDR)  kind = RK_LAST;
        else if (int'(rd_addr) == STAT_ADDR)  kind = RK_STAT;
        else                                  kind = RK_NONE;
    end

    // Derive the clears caused by a strobed read.
    always_comb begin
        eoc_clr  = '0;
        drdy_clr = 1'b0;
        ovr_clr  = 1'b0;
        if (rd_en) begin
            unique case (kind)
                RK_CHAN: begin
                    eoc_clr[sel_ch] = 1'b1;
                    drdy_clr        = 1'b1;
                end
                RK_LAST: begin
                    if (int'(last_ch) < NUM_CH) eoc_clr[last_ch] = 1'b1;
                    drdy_clr = 1'b1;
                end
                RK_STAT: ovr_clr = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_sample_store.sv
// Module adc_sample_store
// Holds one result register per channel plus the most recent result and
// its channel. Samples are right-aligned; in low-resolution mode the
// upper bits are forced to zero.
// Assumes: conv_ch is below NUM_CH whenever conv_done is high; other
// values update only the most-recent register.
module adc_sample_store #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int DATA_W = 10,
    parameter int LOW_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           res8,
    input  logic                           conv_done,
    input  logic [CH_W-1:0]                conv_ch,
    input  logic [DATA_W-1:0]              conv_data,
    output logic [NUM_CH-1:0][DATA_W-1:0]  chan_data,
    output logic [DATA_W-1:0]              last_data,
    output logic [CH_W-1:0]                last_ch
);

    localparam int PAD_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] sample;

    // Right-align the sample for the selected resolution.
    always_comb begin
        if (res8) sample = {{PAD_W{1'b0}}, conv_data[LOW_W-1:0]};
        else      sample = conv_data;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        // Capture the sample when this channel completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chan_data[g] <= '0;
            else if (conv_done && (int'(conv_ch) == g))
                chan_data[g] <= sample;
        end
    end

    // Capture every completion into the most-recent register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
            last_ch   <= '0;
        end else if (conv_done) begin
            last_data <= sample;
            last_ch   <= conv_ch;
        end
    end

endmodule

// File: rtl/adc_flag_tracker.sv
// Module adc_flag_tracker
// Keeps the per-channel new-data and overwrite flags and the global
// data-ready and overwrite flags. A set from a completion beats a clear
// from a read in the same cycle, and the overwrite checks use the flag
// values from before any clear.
module adc_flag_tracker #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [NUM_CH-1:0] eoc_clr,
    input  logic              drdy_clr,
    input  logic              ovr_clr,
    output logic [NUM_CH-1:0] eoc_q,
    output logic [NUM_CH-1:0] ovre_q,
    output logic              drdy_q,
    output logic              govre_q
);

    logic [NUM_CH-1:0] set_vec;

    // One-hot of the channel that completes this cycle.
    always_comb begin
        set_vec = '0;
        if (conv_done && (int'(conv_ch) < NUM_CH)) set_vec[conv_ch] = 1'b1;
    end

    // Update the flags: clear from reads, then OR in the sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q   <= '0;
            ovre_q  <= '0;
            drdy_q  <= 1'b0;
            govre_q <= 1'b0;
        end else begin
            eoc_q   <= (eoc_q & ~eoc_clr) | set_vec;
            ovre_q  <= (ovre_q & {NUM_CH{~ovr_clr}}) | (set_vec & eoc_q);
            drdy_q  <= (drdy_q & ~drdy_clr) | conv_done;
            govre_q <= (govre_q & ~ovr_clr) | (conv_done & drdy_q);
        end
    end

endmodule

// File: rtl/adc_irq_dma.sv
// Module adc_irq_dma
// Holds the interrupt mask and forms the interrupt output. Issues a
// one-cycle DMA request aligned with the rising edge of data-ready.
// Assumes: data-ready rises only through a completion while it is low.
module adc_irq_dma #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [NUM_CH:0]   mask_wdata,
    input  logic              dma_en,
    input  logic              conv_done,
    input  logic [NUM_CH-1:0] eoc_q,
    input  logic              drdy_q,
    output logic              irq,
    output logic              dma_req
);

    logic [NUM_CH:0] mask_q;

    // Load the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Register the DMA pulse so it appears with the data-ready rise.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= dma_en & conv_done & ~drdy_q;
    end

    // Interrupt is any enabled flag that is set.
    always_comb irq = |(mask_q & {drdy_q, eoc_q});

endmodule

// File: rtl/adc_result_bank.sv
// Module adc_result_bank (top)
// Result registers and status flags for a multi-channel ADC: storage,
// flag set/clear rules, read-side-effect clears, interrupt mask and DMA
// trigger.
// Assumes: one completion per cycle at most; rd_data is combinational
// and may be sampled with rd_en low to avoid side effects.
module adc_result_bank
    import adc_result_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10,
    parameter int LOW_W  = 8,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int ADDR_W = $clog2(NUM_CH + 2),
    parameter int RD_W   = 2 * NUM_CH + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res8,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    input  logic              mask_we,
    input  logic [NUM_CH:0]   mask_wdata,
    input  logic              dma_en,
    output logic              irq,
    output logic              dma_req
);

    logic [NUM_CH-1:0][DATA_W-1:0] chan_data;
    logic [DATA_W-1:0]             last_data;
    logic [CH_W-1:0]               last_ch;
    logic [NUM_CH-1:0]             eoc_q, ovre_q, eoc_clr;
    logic                          drdy_q, govre_q, drdy_clr, ovr_clr;
    rd_kind_e                      kind;
    logic [CH_W-1:0]               sel_ch;

    adc_read_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .last_ch  (last_ch),
        .kind     (kind),
        .sel_ch   (sel_ch),
        .eoc_clr  (eoc_clr),
        .drdy_clr (drdy_clr),
        .ovr_clr  (ovr_clr)
    );

    adc_sample_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .res8      (res8),
        .conv_done (conv_done),
        .conv_ch   (conv_ch),
        .conv_data (conv_data),
        .chan_data (chan_data),
        .last_data (last_data),
        .last_ch   (last_ch)
    );

    adc_flag_tracker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_ch   (conv_ch),
        .eoc_clr   (eoc_clr),
        .drdy_clr  (drdy_clr),
        .ovr_clr   (ovr_clr),
        .eoc_q     (eoc_q),
        .ovre_q    (ovre_q),
        .drdy_q    (drdy_q),
        .govre_q   (govre_q)
    );

    adc_irq_dma #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .dma_en     (dma_en),
        .conv_done  (conv_done),
        .eoc_q      (eoc_q),
        .drdy_q     (drdy_q),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    // Select the read data for the addressed register.
    always_comb begin
        unique case (kind)
            RK_CHAN: rd_data = RD_W'(chan_data[sel_ch]);
            RK_LAST: rd_data = RD_W'({last_ch, last_data});
            RK_STAT: rd_data = RD_W'({govre_q, drdy_q, ovre_q, eoc_q});
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_result_bank_chk.sv
// Module adc_result_bank_chk
// Assertion checker for adc_result_bank, attached with bind. It watches
// the ports and the flag registers.
module adc_result_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [CH_W-1:0]   conv_ch,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              dma_en,
    input logic [NUM_CH-1:0] eoc,
    input logic [NUM_CH-1:0] ovre,
    input logic              drdy,
    input logic              govre,
    input logic              irq,
    input logic              dma_req
);

    a_r3_done_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (drdy && eoc[$past(conv_ch)]));

    a_r4_chan_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(rd_addr) < NUM_CH) && !conv_done)
        |=> (!drdy && !eoc[$past(rd_addr[CH_W-1:0])]));

    a_r6_chan_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && eoc[conv_ch]) |=> ovre[$past(conv_ch)]);

    a_r7_global_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && drdy) |=> govre);

    a_r8_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(rd_addr) == NUM_CH + 1) && !conv_done)
        |=> (ovre == '0 && !govre));

    a_r9_dma_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (drdy && !$past(drdy) && $past(dma_en)));

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc == '0 && !drdy) |-> !irq);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rd_en) |=> drdy);

endmodule

bind adc_result_bank adc_result_bank_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_ch   (conv_ch),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .dma_en    (dma_en),
    .eoc       (eoc_q),
    .ovre      (ovre_q),
    .drdy      (drdy_q),
    .govre     (govre_q),
    .irq       (irq),
    .dma_req   (dma_req)
);

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res8 = 1'b0;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_ch = '0;
    logic [9:0]  conv_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [17:0] rd_data;
    logic        mask_we = 1'b0;
    logic [8:0]  mask_wdata = '0;
    logic        dma_en = 1'b0;
    logic        irq, dma_req;

    always #10 clk = ~clk;

    adc_result_bank dut (
        .clk(clk), .rst_n(rst_n), .res8(res8), .conv_done(conv_done),
        .conv_ch(conv_ch), .conv_data(conv_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .dma_en(dma_en), .irq(irq), .dma_req(dma_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // Expected state, built from the requirements.
    int       e_data [8];
    int       e_last = 0;
    int       e_lch = 0;
    bit [7:0] e_eoc = '0, e_ovre = '0;
    bit       e_drdy = 0, e_govre = 0, e_dma = 0;
    bit [8:0] e_mask = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One stimulus cycle followed by the expected-state update.
    task automatic step(input bit done, input int ch, input int data,
                        input bit rd, input int addr,
                        input bit we = 0, input int wmask = 0);
        bit [7:0] clr, setv;
        bit clr_d, clr_o;
        int smp;
        @(negedge clk);
        conv_done = done; conv_ch = 3'(ch); conv_data = 10'(data);
        rd_en = rd; rd_addr = 4'(addr); mask_we = we; mask_wdata = 9'(wmask);
        smp = res8 ? (data & 'hff) : (data & 'h3ff);
        clr = '0; clr_d = 0; clr_o = 0; setv = '0;
        if (rd) begin
            if (addr < 8) begin clr[addr] = 1; clr_d = 1; end
            else if (addr == 8) begin clr[e_lch] = 1; clr_d = 1; end
            else if (addr == 9) clr_o = 1;
        end
        if (done) setv[ch] = 1;
        e_dma   = dma_en & done & !e_drdy;
        e_ovre  = (e_ovre & ~{8{clr_o}}) | (setv & e_eoc);
        e_govre = (e_govre & !clr_o) | (done & e_drdy);
        e_eoc   = (e_eoc & ~clr) | setv;
        e_drdy  = (e_drdy & !clr_d) | done;
        if (done) begin e_data[ch] = smp; e_last = smp; e_lch = ch; end
        if (we) e_mask = 9'(wmask);
        @(negedge clk);
        conv_done = 0; rd_en = 0; mask_we = 0;
        e_dma = 0 | e_dma;
    endtask

    // Look at a register without a strobe (no side effect).
    task automatic peek(input string tag, input int addr, input int exp);
        rd_en = 0; rd_addr = 4'(addr);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    function automatic int stat_word();
        return int'({e_govre, e_drdy, e_ovre, e_eoc});
    endfunction

    function automatic int irq_exp();
        return int'(|(e_mask & {e_drdy, e_eoc}));
    endfunction

    task automatic check_all(input string tag);
        peek(tag, 9, stat_word());
        chk({tag, " irq"}, int'(irq), irq_exp());
        chk({tag, " dma"}, int'(dma_req), int'(e_dma));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) e_data[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        check_all("R12 reset");
        for (int a = 0; a < 9; a++) peek("R12 reset reg", a, 0);

        // R1 R2 R3 R4 R9: sweep both resolutions over all channels
        dma_en = 1;
        for (int r = 0; r < 2; r++) begin
            res8 = r[0];
            for (int ch = 0; ch < 8; ch++) begin
                int d;
                d = (ch * 97 + r * 300 + 773) & 'h3ff;
                step(1, ch, d, 0, 0);
                check_all("R3 R9 after completion");
                peek("R1 channel value", ch, r ? (d & 'hff) : d);
                peek("R2 last value", 8, (ch << 10) | e_last);
                if (ch > 0) peek("R2 other channel kept", ch - 1, e_data[ch - 1]);
                step(0, 0, 0, 1, ch);
                check_all("R4 channel read clears");
            end
        end

        // R6 R7: overwrite detection
        res8 = 0;
        step(1, 3, 'h155, 0, 0);
        step(1, 3, 'h2aa, 0, 0);
        check_all("R6 R7 channel 3 overwrite");
        step(1, 5, 'h011, 0, 0);
        check_all("R6 fresh channel no overwrite");

        // R12: unmapped addresses read zero and clear nothing
        peek("R12 unmapped reads zero", 12, 0);
        step(0, 0, 0, 1, 12);
        check_all("R12 unmapped read no effect");

        // R8: status read clears only the overwrite flags
        step(0, 0, 0, 1, 9);
        check_all("R8 status read");

        // R5: last read clears channel 5 new-data and data-ready only
        step(0, 0, 0, 1, 8);
        check_all("R5 last read");

        // R11: channel read colliding with a completion on the same channel
        step(1, 3, 'h0f0, 1, 3);
        check_all("R11 channel read collision");
        // R11: status read colliding with a fresh overwrite
        step(1, 3, 'h0f1, 1, 9);
        check_all("R11 status read collision");
        // R11: last read colliding with a completion on another channel
        step(1, 6, 'h1e1, 1, 8);
        check_all("R11 last read collision");

        // clean up flags
        for (int c = 0; c < 8; c++) step(0, 0, 0, 1, c);
        step(0, 0, 0, 1, 9);
        check_all("R4 R8 flags cleared");

        // R10: interrupt mask
        step(0, 0, 0, 0, 0, 1, 'h004);
        check_all("R10 mask loaded, no flags");
        step(1, 1, 'h021, 0, 0);
        check_all("R10 masked channel no irq");
        step(1, 2, 'h022, 0, 0);
        check_all("R10 enabled channel irq");
        step(0, 0, 0, 1, 2);
        check_all("R10 irq drops after read");
        step(0, 0, 0, 0, 0, 1, 'h100);
        check_all("R10 data-ready enable");
        step(0, 0, 0, 1, 1);
        check_all("R10 data-ready cleared");

        // R9: DMA disabled gives no request
        dma_en = 0;
        step(1, 4, 'h077, 0, 0);
        check_all("R9 dma disabled");
        dma_en = 1;
        step(1, 4, 'h078, 0, 0);
        check_all("R9 no new edge while high");

        // R12: reset clears everything again
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 8; i++) e_data[i] = 0;
        e_last = 0; e_lch = 0; e_eoc = '0; e_ovre = '0;
        e_drdy = 0; e_govre = 0; e_dma = 0; e_mask = '0;
        check_all("R12 second reset");
        peek("R12 channel 4 cleared", 4, 0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule